// File: doc/BRIEF.md
# Configurable Edge Event Flag Unit

This unit watches one pin of a pin bus for a chosen kind of transition and turns each match into an event. Every match produces a single-cycle pulse, and it also sets a sticky flag that stays set until it is consumed. A configuration write chooses the pin index and the edge kind together. A single get/wait strobe reads the flag and clears it. The wait-release output tells a stalled wait instruction whether it may proceed.

The raw pulse leaves the block as an interrupt source. It does not depend on the sticky flag, so an interrupt still fires when the flag has already been set by an earlier event. After each configuration write, a fixed two-cycle blanking window holds back event generation. The saved previous pin sample is reloaded as the window ends, so a change of pin or edge kind never shows up as a false edge. The pins are assumed to be synchronised before they reach this block.

Top module: `evt_edge_unit`

## Requirements
- R1: While reset is held and after it is released, the flag is clear, no event pulse occurs and the unit is in the off mode with pin index 0 selected.
- R2: A configuration write (cfg_wr_i high at a rising clock edge) loads the pin index (cfg_pin_i, binary) and the edge mode (cfg_mode_i: 00 off, 01 rising, 10 falling, 11 either). Pins other than the selected one never cause an event.
- R3: In rising mode, event_o is high in exactly those cycles where the selected pin reads 1 and read 0 in the previous cycle.
- R4: In falling mode, event_o is high in exactly those cycles where the selected pin reads 0 and read 1 in the previous cycle.
- R5: In either-edge mode, event_o is high in every cycle where the selected pin differs from its value in the previous cycle.
- R6: In off mode, event_o stays low whatever the pins do.
- R7: event_o stays low in the cycle that follows a configuration write and in the cycle after that. The first comparison after this window uses the pin value seen in the last blanked cycle as the previous value.
- R8: An event sets flag_o from the next cycle on. The flag then stays set until a get/wait strobe clears it.
- R9: A get/wait strobe (poll_i) clears the flag from the next cycle on, even when the caller ignores the flag value. If an event occurs in the same cycle as the strobe, the event wins and the flag stays set.
- R10: release_o is high in exactly those cycles where poll_i is high and flag_o is set.
- R11: event_o pulses on every match even while the flag is already set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NUM_PINS | Synchronised pin bus |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_pin_i | input | $clog2(NUM_PINS) | Pin index to watch |
| cfg_mode_i | input | 2 | Edge mode: 00 off, 01 rising, 10 falling, 11 either |
| poll_i | input | 1 | Get/wait strobe that reads and clears the flag |
| event_o | output | 1 | Raw single-cycle event pulse for the interrupt logic |
| flag_o | output | 1 | Sticky event flag |
| release_o | output | 1 | Waiting instruction may proceed |

## Verification
The hardest cases to reach are the ones where several conditions meet in one cycle. One is a pin transition that falls inside the blanking window. Another is a configuration write made while an earlier window is still running. A third is a strobe that lands in the very cycle an event fires. A purely random mix rarely lines these up. The bench therefore runs directed sequences that toggle the newly selected pin in both blanked cycles, that issue back-to-back writes, and that strobe on a known edge. After that comes a long random run where writes, strobes and pin toggles are frequent enough to collide often. A cycle-level model written from the requirements gives the expected values.

// File: rtl/evt_pkg.sv
package evt_pkg;

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    localparam int unsigned BLANK_LEN = 2;
    localparam int unsigned BLANK_W   = $clog2(BLANK_LEN + 1);

    typedef struct packed {
        logic prev;
        logic cur;
    } pin_pair_t;

    function automatic logic edge_hit(edge_mode_e mode, pin_pair_t p);
        logic h;
        case (mode)
            EDGE_RISE: h = p.cur & ~p.prev;
            EDGE_FALL: h = p.prev & ~p.cur;
            EDGE_BOTH: h = p.cur ^ p.prev;
            default:   h = 1'b0;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/evt_cfg.sv
module evt_cfg
    import evt_pkg::*;
#(
    parameter int unsigned PIN_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr_i,
    input  logic [PIN_W-1:0] cfg_pin_i,
    input  logic [1:0]       cfg_mode_i,
    output logic [PIN_W-1:0] sel_pin_o,
    output edge_mode_e       mode_o,
    output logic             blank_o,
    output logic             sample_en_o
);

    logic [PIN_W-1:0]   pin_q;
    edge_mode_e         mode_q;
    logic [BLANK_W-1:0] blank_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_q   <= '0;
            mode_q  <= EDGE_OFF;
            blank_q <= '0;
        end else if (cfg_wr_i) begin
            pin_q   <= cfg_pin_i;
            mode_q  <= edge_mode_e'(cfg_mode_i);
            blank_q <= BLANK_W'(BLANK_LEN);
        end else if (blank_q != '0) begin
            blank_q <= blank_q - 1'b1;
        end
    end

    assign sel_pin_o   = pin_q;
    assign mode_o      = mode_q;
    assign blank_o     = (blank_q != '0);
    // previous sample follows the pin when idle and is reloaded in the last blanked cycle
    assign sample_en_o = !cfg_wr_i && (blank_q <= BLANK_W'(1));

endmodule

// File: rtl/evt_detect.sv
module evt_detect
    import evt_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32,
    parameter int unsigned PIN_W    = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic [PIN_W-1:0]    sel_pin_i,
    input  edge_mode_e          mode_i,
    input  logic                blank_i,
    input  logic                sample_en_i,
    output logic                hit_o
);

    pin_pair_t pair;
    logic      prev_q;

    assign pair.cur  = pins_i[sel_pin_i];
    assign pair.prev = prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
        end else if (sample_en_i) begin
            prev_q <= pair.cur;
        end
    end

    assign hit_o = !blank_i && edge_hit(mode_i, pair);

endmodule

// File: rtl/evt_flag.sv
module evt_flag (
    input  logic clk,
    input  logic rst,
    input  logic event_i,
    input  logic poll_i,
    output logic flag_o,
    output logic release_o
);

    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= event_i | (flag_q & ~poll_i);
        end
    end

    assign flag_o    = flag_q;
    assign release_o = poll_i & flag_q;

    a_r8_event_sets_flag: assert property (@(posedge clk) disable iff (rst)
        event_i |=> flag_q);

    a_r8_flag_holds: assert property (@(posedge clk) disable iff (rst)
        flag_q && !poll_i && !event_i |=> flag_q);

    a_r9_poll_clears: assert property (@(posedge clk) disable iff (rst)
        poll_i && !event_i |=> !flag_q);

    a_r9_event_wins: assert property (@(posedge clk) disable iff (rst)
        poll_i && event_i |=> flag_q);

endmodule

// File: rtl/evt_edge_unit.sv
module evt_edge_unit
    import evt_pkg::*;
#(
    parameter int unsigned NUM_PINS = 32,
    localparam int unsigned PIN_W   = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic                cfg_wr_i,
    input  logic [PIN_W-1:0]    cfg_pin_i,
    input  logic [1:0]          cfg_mode_i,
    input  logic                poll_i,
    output logic                event_o,
    output logic                flag_o,
    output logic                release_o
);

    logic [PIN_W-1:0] sel_pin;
    edge_mode_e       mode;
    logic             blank;
    logic             sample_en;
    logic             hit;

    evt_cfg #(.PIN_W(PIN_W)) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .cfg_wr_i    (cfg_wr_i),
        .cfg_pin_i   (cfg_pin_i),
        .cfg_mode_i  (cfg_mode_i),
        .sel_pin_o   (sel_pin),
        .mode_o      (mode),
        .blank_o     (blank),
        .sample_en_o (sample_en)
    );

    evt_detect #(.NUM_PINS(NUM_PINS), .PIN_W(PIN_W)) u_detect (
        .clk         (clk),
        .rst         (rst),
        .pins_i      (pins_i),
        .sel_pin_i   (sel_pin),
        .mode_i      (mode),
        .blank_i     (blank),
        .sample_en_i (sample_en),
        .hit_o       (hit)
    );

    evt_flag u_flag (
        .clk       (clk),
        .rst       (rst),
        .event_i   (hit),
        .poll_i    (poll_i),
        .flag_o    (flag_o),
        .release_o (release_o)
    );

    assign event_o = hit;

    a_r7_blank_first: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_i |=> !event_o);

    a_r7_blank_second: assert property (@(posedge clk) disable iff (rst)
        $past(cfg_wr_i) |=> !event_o);

    a_r6_off_silent: assert property (@(posedge clk) disable iff (rst)
        mode == EDGE_OFF |-> !event_o);

    a_r1_reset_clear: assert property (@(posedge clk)
        rst |=> !flag_o);

endmodule

// File: tb/test_evt_edge_unit.sv
module test_evt_edge_unit;

    localparam int unsigned CLK_PERIOD = 10;
    localparam int unsigned NUM_PINS   = 32;
    localparam int unsigned PIN_W      = $clog2(NUM_PINS);

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic [NUM_PINS-1:0] pins = '0;
    logic                cfg_wr = 1'b0;
    logic [PIN_W-1:0]    cfg_pin = '0;
    logic [1:0]          cfg_mode = 2'b00;
    logic                poll = 1'b0;
    logic                event_o, flag_o, release_o;

    int unsigned n_checks = 0;
    int unsigned n_fail   = 0;
    bit          done     = 1'b0;

    // reference model state
    logic [PIN_W-1:0] m_pin   = '0;
    logic [1:0]       m_mode  = 2'b00;
    int unsigned      m_blank = 0;
    logic             m_prev  = 1'b0;
    logic             m_flag  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    evt_edge_unit #(.NUM_PINS(NUM_PINS)) i_evt_edge_unit (
        .clk        (clk),
        .rst        (rst),
        .pins_i     (pins),
        .cfg_wr_i   (cfg_wr),
        .cfg_pin_i  (cfg_pin),
        .cfg_mode_i (cfg_mode),
        .poll_i     (poll),
        .event_o    (event_o),
        .flag_o     (flag_o),
        .release_o  (release_o)
    );

    function automatic logic exp_hit(logic [1:0] md, logic pv, logic cu);
        case (md)
            2'b01:   return cu && !pv;
            2'b10:   return pv && !cu;
            2'b11:   return cu != pv;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(logic got, logic exp, string req);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic step(logic [NUM_PINS-1:0] p, logic wr, logic [PIN_W-1:0] pi,
                        logic [1:0] md, logic pl);
        logic cur, e_ev;
        string tag;
        @(negedge clk);
        pins = p; cfg_wr = wr; cfg_pin = pi; cfg_mode = md; poll = pl;
        #1;
        cur  = p[m_pin];
        e_ev = (m_blank == 0) && exp_hit(m_mode, m_prev, cur);
        if (m_blank != 0)          tag = "R7";
        else if (e_ev && m_flag)   tag = "R11";
        else if (m_mode == 2'b01)  tag = "R3";
        else if (m_mode == 2'b10)  tag = "R4";
        else if (m_mode == 2'b11)  tag = "R5";
        else                       tag = "R6";
        chk(event_o, e_ev, tag);
        chk(flag_o, m_flag, pl ? "R9" : "R8");
        chk(release_o, pl && m_flag, "R10");
        @(posedge clk);
        m_flag = e_ev || (m_flag && !pl);
        if (wr) begin
            m_pin = pi; m_mode = md; m_blank = 2;
        end else if (m_blank == 2) begin
            m_blank = 1;
        end else begin
            m_blank = 0; m_prev = cur;
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [NUM_PINS-1:0] pv;
        void'($urandom(32'd4711));
        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(flag_o, 1'b0, "R1");
        chk(event_o, 1'b0, "R1");
        @(negedge clk);
        rst = 1'b0;
        // R1/R6: off mode after reset, pins toggling
        for (int i = 0; i < 4; i++) step(~pins, 1'b0, '0, 2'b00, 1'b0);
        // R2: rising on pin 5; toggle in blank window (R7)
        pv = '0;
        step(pv, 1'b1, 5'd5, 2'b01, 1'b0);
        pv[5] = 1'b1; step(pv, 1'b0, '0, 2'b00, 1'b0);
        pv[5] = 1'b0; step(pv, 1'b0, '0, 2'b00, 1'b0);
        pv[5] = 1'b1; step(pv, 1'b0, '0, 2'b00, 1'b0);   // R3 rising edge
        step(pv, 1'b0, '0, 2'b00, 1'b0);
        pv[3] = 1'b1; step(pv, 1'b0, '0, 2'b00, 1'b0);   // R2 unselected pin
        pv[3] = 1'b0; step(pv, 1'b0, '0, 2'b00, 1'b0);
        pv[5] = 1'b0; step(pv, 1'b0, '0, 2'b00, 1'b0);
        pv[5] = 1'b1; step(pv, 1'b0, '0, 2'b00, 1'b0);   // R11 flag already set
        step(pv, 1'b0, '0, 2'b00, 1'b1);                 // R9/R10 poll clears
        step(pv, 1'b0, '0, 2'b00, 1'b0);
        pv[5] = 1'b0; step(pv, 1'b0, '0, 2'b00, 1'b0);
        pv[5] = 1'b1; step(pv, 1'b0, '0, 2'b00, 1'b1);   // R9 event wins over poll
        step(pv, 1'b0, '0, 2'b00, 1'b1);
        // back-to-back writes, falling on pin 31 then either on pin 0
        step(pv, 1'b1, 5'd31, 2'b10, 1'b0);
        pv[31] = 1'b1; step(pv, 1'b1, 5'd0, 2'b11, 1'b0);
        pv[0] = 1'b1; step(pv, 1'b0, '0, 2'b00, 1'b0);
        pv[0] = 1'b0; step(pv, 1'b0, '0, 2'b00, 1'b0);
        pv[0] = 1'b1; step(pv, 1'b0, '0, 2'b00, 1'b0);   // R5
        pv[0] = 1'b0; step(pv, 1'b0, '0, 2'b00, 1'b0);
        step(pv, 1'b1, 5'd31, 2'b10, 1'b1);
        step(pv, 1'b0, '0, 2'b00, 1'b0);
        step(pv, 1'b0, '0, 2'b00, 1'b0);
        pv[31] = 1'b0; step(pv, 1'b0, '0, 2'b00, 1'b0);  // R4
        // random phase
        for (int i = 0; i < 4000; i++) begin
            logic [NUM_PINS-1:0] np;
            logic wr, pl;
            np = pins ^ ($urandom & $urandom & $urandom);
            wr = ($urandom % 12) == 0;
            pl = ($urandom % 4) == 0;
            step(np, wr, PIN_W'($urandom % 4), 2'($urandom), pl);
        end
        finish_run();
    end

endmodule